// File: doc/BRIEF.md
# Masked DAC Channel Programming Parser

This block consumes a byte stream that carries one DAC programming packet at a time, with network framing already stripped. A leading command byte marks the packet. A channel-select mask follows it, and then a fixed-length section of 14-bit channel values. The block keeps a shadow copy of every DAC channel value. When a packet completes, it writes only the channels whose mask bit is set.

Channel values arrive highest channel first, two bytes per channel. The upper byte carries the six most significant value bits in its low six positions. All incoming words are held in a staging area until the final channel byte arrives, and the shadow registers are then updated in a single cycle. A packet that ends early therefore leaves the shadow state untouched and raises an error pulse. Bytes that follow the last channel, such as padding up to a minimum payload size, are dropped until the end marker.

The channel count is a parameter: 32, 24 or 16. The mask length (channel count / 8 bytes) and the data length (2 × channel count bytes) follow from it. A combinational read port exposes the shadow values, for example to a response builder or a serial DAC driver.

Top module: `dac_prog_parser`

## Requirements
- R1: After reset every shadow value reads 0, `done_o` and `err_o` are low, and `in_ready_o` is high.
- R2: A packet is parsed only when its start byte (`in_sop_i` high) equals `CMD_CODE` (default 8'h50). A packet that starts with any other byte is ignored completely: no update, no `done_o`, no `err_o`.
- R3: The command byte is followed by NUM_CH/8 mask bytes, most significant byte first. Mask bit n selects channel n.
- R4: The data section holds two bytes per channel, channel NUM_CH-1 first and channel 0 last. Value bits [13:8] come from bits [5:0] of the first byte, and bits [7:0] come from the second byte. Bits [7:6] of the first byte are ignored.
- R5: On a completed packet, only channels with a set mask bit take their new value. All other shadow values keep their previous value whatever bytes were sent for them.
- R6: In the cycle after the last channel byte is accepted, `done_o` is high for exactly one cycle. In that cycle `done_map_o` equals the mask, and the shadow reads return the new values.
- R7: Bytes after the last channel byte, up to and including the end marker, are ignored.
- R8: If `in_eop_i` arrives with a byte before the last channel byte (including on the command or mask bytes), no shadow value changes, no `done_o` occurs, and `err_o` pulses for one cycle in the following cycle.
- R9: `rd_data_o` shows the shadow value at `rd_addr_i` combinationally. Addresses at or above NUM_CH read 0.
- R10: `in_ready_o` stays high. Cycles with `in_valid_i` low have no effect, whatever the other input pins carry.
- R11: A start byte in the middle of a packet abandons the partial packet without `err_o` and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted (always high) |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | Byte is the first of a packet |
| in_eop_i | input | 1 | Byte is the last of a packet |
| rd_addr_i | input | $clog2(NUM_CH) | Shadow read address |
| rd_data_o | output | 14 | Shadow value at rd_addr_i |
| done_o | output | 1 | One-cycle pulse on packet completion |
| done_map_o | output | NUM_CH | Bitmap of channels written by the last packet |
| err_o | output | 1 | One-cycle pulse on a truncated packet |

## Verification
The bench builds the block with NUM_CH = 24. This setting exercises a three-byte mask whose channel count is not a power of two. It also leaves the read addresses 24 to 31 beyond the channel range, which checks that those addresses read zero. The 48-byte data section sits just above the 46-byte payload minimum, so padding, truncation at the mask and in the data, wrong command codes, idle gaps and restarts are all driven in full-width packets.

// File: rtl/dac_prog_pkg.sv
package dac_prog_pkg;
  localparam int unsigned VAL_W = 14;
  localparam int unsigned HI_W  = VAL_W - 8;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_MASK,
    PS_DATA,
    PS_PAD
  } parse_st_e;
endpackage

// File: rtl/dac_prog_seq.sv
module dac_prog_seq
  import dac_prog_pkg::*;
#(
  parameter int unsigned NUM_CH   = 32,
  parameter logic [7:0]  CMD_CODE = 8'h50,
  localparam int unsigned DATA_BYTES = 2 * NUM_CH,
  localparam int unsigned CNT_W      = $clog2(DATA_BYTES),
  localparam int unsigned CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              stage_we_o,
  output logic [CH_W-1:0]   stage_ch_o,
  output logic [VAL_W-1:0]  word_o,
  output logic              commit_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              err_o
);
  localparam int unsigned MASK_BYTES = NUM_CH / 8;

  parse_st_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HI_W-1:0]   hi_q;
  logic [NUM_CH-1:0] mask_q;
  logic              err_q;
  logic              last_mask, last_data, err_d;

  assign last_mask = (cnt_q == CNT_W'(MASK_BYTES - 1));
  assign last_data = (cnt_q == CNT_W'(DATA_BYTES - 1));

  // first word on the wire is the highest channel
  assign stage_ch_o = CH_W'(NUM_CH - 1) - cnt_q[CNT_W-1:1];
  assign word_o     = {hi_q, byte_i};
  assign stage_we_o = byte_vld_i && !sop_i && (state_q == PS_DATA) && cnt_q[0];
  assign commit_o   = stage_we_o && last_data;
  assign mask_o     = mask_q;
  assign err_o      = err_q;

  always_comb begin
    err_d = 1'b0;
    if (byte_vld_i && eop_i) begin
      if (sop_i) err_d = (byte_i == CMD_CODE);
      else       err_d = (state_q == PS_MASK) || ((state_q == PS_DATA) && !last_data);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      hi_q    <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (byte_vld_i) begin
        if (sop_i) begin
          cnt_q   <= '0;
          mask_q  <= '0;
          state_q <= (byte_i == CMD_CODE && !eop_i) ? PS_MASK : PS_IDLE;
        end else begin
          unique case (state_q)
            PS_MASK: begin
              mask_q <= {mask_q[NUM_CH-9:0], byte_i};
              if (eop_i) state_q <= PS_IDLE;
              else if (last_mask) begin
                state_q <= PS_DATA;
                cnt_q   <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            PS_DATA: begin
              if (!cnt_q[0]) hi_q <= byte_i[HI_W-1:0];
              if (eop_i) state_q <= PS_IDLE;
              else if (last_data) state_q <= PS_PAD;
              else cnt_q <= cnt_q + 1'b1;
            end
            PS_PAD:  if (eop_i) state_q <= PS_IDLE;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dac_prog_stage.sv
module dac_prog_stage
  import dac_prog_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [CH_W-1:0]              ch_i,
  input  logic [VAL_W-1:0]             word_i,
  output logic [(NUM_CH-1)*VAL_W-1:0]  stage_o
);
  // channel 0 is never staged: it arrives together with the commit
  for (genvar k = 1; k < NUM_CH; k++) begin : g_ch
    logic [VAL_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            val_q <= '0;
      else if (we_i && ch_i == CH_W'(k))      val_q <= word_i;
    end
    assign stage_o[(k-1)*VAL_W +: VAL_W] = val_q;
  end
endmodule

// File: rtl/dac_prog_shadow.sv
module dac_prog_shadow
  import dac_prog_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         commit_i,
  input  logic [NUM_CH-1:0]            mask_i,
  input  logic [(NUM_CH-1)*VAL_W-1:0]  stage_i,
  input  logic [VAL_W-1:0]             word_i,
  input  logic [CH_W-1:0]              rd_addr_i,
  output logic [VAL_W-1:0]             rd_data_o,
  output logic [NUM_CH*VAL_W-1:0]      shadow_o
);
  logic [VAL_W-1:0] shadow_q [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [VAL_W-1:0] nxt;
    if (k == 0) begin : g_live
      assign nxt = word_i;
    end else begin : g_staged
      assign nxt = stage_i[(k-1)*VAL_W +: VAL_W];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    shadow_q[k] <= '0;
      else if (commit_i && mask_i[k]) shadow_q[k] <= nxt;
    end
    assign shadow_o[k*VAL_W +: VAL_W] = shadow_q[k];
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (rd_addr_i == CH_W'(k)) rd_data_o = shadow_q[k];
  end
endmodule

// File: rtl/dac_prog_parser.sv
module dac_prog_parser
  import dac_prog_pkg::*;
#(
  parameter int unsigned NUM_CH   = 32,
  parameter logic [7:0]  CMD_CODE = 8'h50,
  localparam int unsigned ADDR_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [VAL_W-1:0]  rd_data_o,
  output logic              done_o,
  output logic [NUM_CH-1:0] done_map_o,
  output logic              err_o
);
  logic                        stage_we, commit_w;
  logic [ADDR_W-1:0]           stage_ch;
  logic [VAL_W-1:0]            word;
  logic [NUM_CH-1:0]           mask;
  logic [(NUM_CH-1)*VAL_W-1:0] stage_flat;
  logic [NUM_CH*VAL_W-1:0]     shadow_w;
  logic                        done_q;
  logic [NUM_CH-1:0]           map_q;

  assign in_ready_o = 1'b1;

  dac_prog_seq #(.NUM_CH(NUM_CH), .CMD_CODE(CMD_CODE)) u_seq (
    .clk_i, .rst_ni,
    .byte_vld_i (in_valid_i),
    .byte_i     (in_data_i),
    .sop_i      (in_sop_i),
    .eop_i      (in_eop_i),
    .stage_we_o (stage_we),
    .stage_ch_o (stage_ch),
    .word_o     (word),
    .commit_o   (commit_w),
    .mask_o     (mask),
    .err_o      (err_o)
  );

  dac_prog_stage #(.NUM_CH(NUM_CH)) u_stage (
    .clk_i, .rst_ni,
    .we_i    (stage_we),
    .ch_i    (stage_ch),
    .word_i  (word),
    .stage_o (stage_flat)
  );

  dac_prog_shadow #(.NUM_CH(NUM_CH)) u_shadow (
    .clk_i, .rst_ni,
    .commit_i  (commit_w),
    .mask_i    (mask),
    .stage_i   (stage_flat),
    .word_i    (word),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .shadow_o  (shadow_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      map_q  <= '0;
    end else begin
      done_q <= commit_w;
      if (commit_w) map_q <= mask;
    end
  end

  assign done_o     = done_q;
  assign done_map_o = map_q;
endmodule

// File: rtl/dac_prog_parser_chk.sv
module dac_prog_parser_chk #(
  parameter int unsigned NUM_CH = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_eop_i,
  input logic                 done_o,
  input logic                 err_o,
  input logic                 commit_w,
  input logic [NUM_CH*14-1:0] shadow_w
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(in_valid_i)); // R6
  AST_ERR_ON_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(in_valid_i && in_eop_i)); // R8
  AST_NO_DONE_WITH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> $stable(shadow_w)); // R5
endmodule

bind dac_prog_parser dac_prog_parser_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_eop_i   (in_eop_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .commit_w   (commit_w),
  .shadow_w   (shadow_w)
);

// File: tb/dac_prog_parser_bench.sv
module dac_prog_parser_bench;
  localparam int NCH = 24;
  localparam int NB  = NCH / 8;
  localparam int ND  = 2 * NCH;
  localparam logic [7:0] CMD = 8'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]     in_data = '0;
  logic           in_ready;
  logic [4:0]     rd_addr = '0;
  logic [13:0]    rd_data;
  logic           done, err;
  logic [NCH-1:0] done_map;

  dac_prog_parser #(.NUM_CH(NCH), .CMD_CODE(CMD)) u_dac_prog_parser (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .done_o(done),
    .done_map_o(done_map), .err_o(err)
  );

  int checks = 0, errors = 0, cyc = 0;
  int done_cnt = 0, err_cnt = 0, done_cyc = 0, err_cyc = 0;
  int last_chan_cyc = 0, eop_cyc = 0, pkt_len = 0;
  logic [NCH-1:0] map_seen = '0;
  logic [13:0] model [NCH];
  logic [13:0] tx_vals [NCH];
  logic [7:0]  pkt [128];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (done) begin done_cnt++; done_cyc = cyc; map_seen = done_map; end
    if (err)  begin err_cnt++;  err_cyc = cyc; end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_vals(int seed);
    for (int c = 0; c < NCH; c++) tx_vals[c] = 14'(c * 1237 + seed * 977 + 5);
  endtask

  task automatic apply_model(logic [NCH-1:0] m);
    for (int c = 0; c < NCH; c++) if (m[c]) model[c] = tx_vals[c];
  endtask

  // R3 R4 byte layout: cmd, mask MSB byte first, channel NCH-1 first
  task automatic build(logic [7:0] cmd, logic [NCH-1:0] m, int n_data, int n_pad,
                       logic [1:0] junk);
    pkt[0] = cmd;
    for (int b = 0; b < NB; b++) pkt[1+b] = m[(NB-1-b)*8 +: 8];
    for (int i = 0; i < n_data; i++) begin
      int c = NCH - 1 - i / 2;
      pkt[1+NB+i] = (i % 2 == 0) ? {junk, tx_vals[c][13:8]} : tx_vals[c][7:0];
    end
    for (int i = 0; i < n_pad; i++) pkt[1+NB+n_data+i] = 8'hA5 ^ 8'(i);
    pkt_len = 1 + NB + n_data + n_pad;
  endtask

  task automatic send(int gap_every, bit eop_last);
    for (int i = 0; i < pkt_len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pkt[i];
      in_sop = (i == 0); in_eop = eop_last && (i == pkt_len - 1);
      if (i == NB + ND) last_chan_cyc = cyc;
      if (in_eop) eop_cyc = cyc;
      if (gap_every > 0 && (i % gap_every) == 1 && i < pkt_len - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1; in_data = CMD;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < NCH; a++) begin
      rd_addr = 5'(a); #1;
      chk(req, rd_data, model[a]);
    end
  endtask

  task automatic t_reset;
    chk("R1 ready", in_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a); #1;
      chk("R1 zero", rd_data, 0);
    end
  endtask

  task automatic t_full;
    int d0 = done_cnt, e0 = err_cnt;
    fill_vals(1);
    build(CMD, '1, ND, 0, 2'b11);
    send(0, 1);
    apply_model('1);
    chk("R6 one done", done_cnt - d0, 1);
    chk("R6 timing", done_cyc, last_chan_cyc + 1);
    chk("R6 map", map_seen, {NCH{1'b1}});
    chk("R8 no err", err_cnt - e0, 0);
    check_all("R4 values");
  endtask

  task automatic t_sparse;
    logic [NCH-1:0] m = 24'h800081;
    fill_vals(2);
    build(CMD, m, ND, 0, 2'b10);
    send(0, 1);
    apply_model(m);
    chk("R3 map", map_seen, m);
    check_all("R5 sparse");
    m = 24'h010000;
    fill_vals(3);
    build(CMD, m, ND, 0, 2'b01);
    send(0, 1);
    apply_model(m);
    chk("R3 map single", map_seen, m);
    check_all("R3 bit order");
  endtask

  task automatic t_pad;
    logic [NCH-1:0] m = 24'h0F0F0F;
    int d0 = done_cnt, e0 = err_cnt;
    fill_vals(4);
    build(CMD, m, ND, 12, 2'b00);
    send(0, 1);
    apply_model(m);
    chk("R7 one done", done_cnt - d0, 1);
    chk("R7 timing", done_cyc, last_chan_cyc + 1);
    chk("R7 no err", err_cnt - e0, 0);
    check_all("R7 pad ignored");
  endtask

  task automatic t_early;
    int d0 = done_cnt, e0 = err_cnt;
    fill_vals(5);
    build(CMD, '1, 31, 0, 2'b00);
    send(0, 1);
    chk("R8 err", err_cnt - e0, 1);
    chk("R8 err timing", err_cyc, eop_cyc + 1);
    chk("R8 no done", done_cnt - d0, 0);
    check_all("R8 unchanged");
    build(CMD, '1, 0, 0, 2'b00);
    send(0, 1);
    chk("R8 err mask", err_cnt - e0, 2);
    chk("R8 no done mask", done_cnt - d0, 0);
    check_all("R8 unchanged mask");
  endtask

  task automatic t_badcmd;
    int d0 = done_cnt, e0 = err_cnt;
    fill_vals(6);
    build(8'h44, '1, ND, 0, 2'b00);
    send(0, 1);
    chk("R2 no done", done_cnt - d0, 0);
    chk("R2 no err", err_cnt - e0, 0);
    check_all("R2 unchanged");
  endtask

  task automatic t_gap;
    logic [NCH-1:0] m = 24'hAAAAAA;
    int d0 = done_cnt, e0 = err_cnt;
    fill_vals(7);
    build(CMD, m, ND, 0, 2'b11);
    send(3, 1);
    apply_model(m);
    chk("R10 one done", done_cnt - d0, 1);
    chk("R10 no err", err_cnt - e0, 0);
    chk("R10 map", map_seen, m);
    check_all("R10 values");
  endtask

  task automatic t_restart;
    logic [NCH-1:0] m = 24'h00FFFF;
    int d0 = done_cnt, e0 = err_cnt;
    fill_vals(8);
    build(CMD, '1, 20, 0, 2'b00);
    send(0, 0);
    fill_vals(9);
    build(CMD, m, ND, 0, 2'b00);
    send(0, 1);
    apply_model(m);
    chk("R11 one done", done_cnt - d0, 1);
    chk("R11 no err", err_cnt - e0, 0);
    check_all("R11 values");
  endtask

  task automatic t_oob;
    for (int a = NCH; a < 32; a++) begin
      rd_addr = 5'(a); #1;
      chk("R9 out of range", rd_data, 0);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full();
    t_sparse();
    t_pad();
    t_early();
    t_badcmd();
    t_gap();
    t_restart();
    t_oob();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule